// File: doc/BRIEF.md
# Infrared Port Status Register

This block is a single byte-wide register in the console I/O space that controls an infrared link. The CPU writes a transmitter LED bit and a two-bit receive-enable field. On reads it gets those stored bits back, with constant-one filler in the unused positions and a received-light flag.

The received-light flag is set only when both receive-enable bits are 1 and light is present. Light is present when any of three sources is active: the external optical sensor, the console's own LED (a transmitter sees its own light), or an LED on the cartridge side.

When the colour-mode input is low, the register is not implemented and every read returns all ones. The data path is a plain register port with a write strobe and a combinational read value. No valid/ready handshake is used, because the CPU access always completes in one cycle.

Top module: `ir_status_reg`

## Requirements
- R1: When `color_mode_i` is 0, `rd_data_o` is 8'hFF regardless of stored state and light inputs.
- R2: When `color_mode_i` is 1, bits 5 down to 2 of `rd_data_o` always read 1.
- R3: When `color_mode_i` is 1, `rd_data_o[7]`, `rd_data_o[6]` and `rd_data_o[0]` equal the stored receive-enable high bit, receive-enable low bit and LED bit.
- R4: When `color_mode_i` is 1, `rd_data_o[1]` is 1 only if stored bits 7 and 6 are both 1 and light is detected.
- R5: Light is detected when `sensor_i` is 1, or the stored LED bit (bit 0) is 1, or `cart_led_i` is 1.
- R6: A write stores only data bits 7, 6 and 0; written bits 5 down to 1 have no effect on any later read.
- R7: After reset the stored bits are 0: the LED is off and receiving is disabled, so a colour-mode read returns 8'h3C.
- R8: A write takes effect on the rising clock edge where `wr_en_i` is 1. Without the strobe, the stored bits hold. The read value follows the current inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| color_mode_i | input | 1 | 1 when the register is implemented (colour mode) |
| wr_en_i | input | 1 | Write strobe for the register |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Combinational read value |
| sensor_i | input | 1 | External optical sensor, 1 = light seen |
| cart_led_i | input | 1 | Cartridge-side LED, 1 = lit |

## Verification
The checker tests several rules on every clock cycle. It checks the all-ones read outside colour mode and the filler bits. It checks that the received-light flag never appears without both enable bits, and always appears with both enables and an active source. It also checks that stored bits change only under the strobe and take exactly bits 7, 6 and 0 of the written data.

Some behaviour shows only in the bench's scenarios: the reset value, and the self-view of the console LED. The bench also shows that a written bit 1 never leaks into the received-light flag, and how the three light sources combine across random sequences.

// File: rtl/ir_pkg.sv
package ir_pkg;
  localparam int unsigned IR_DATA_W   = 8;
  localparam int unsigned IR_BIT_ENHI = 7;
  localparam int unsigned IR_BIT_ENLO = 6;
  localparam int unsigned IR_BIT_RX   = 1;
  localparam int unsigned IR_BIT_LED  = 0;
  localparam int unsigned IR_FILL_HI  = 5;
  localparam int unsigned IR_FILL_LO  = 2;
  localparam int unsigned IR_FILL_W   = IR_FILL_HI - IR_FILL_LO + 1;
  localparam int unsigned IR_NUM_SRC  = 3;

  typedef struct packed {
    logic en_hi;
    logic en_lo;
    logic led;
  } ir_ctrl_t;
endpackage

// File: rtl/ir_ctrl_store.sv
module ir_ctrl_store
  import ir_pkg::*;
#(
  parameter int unsigned DATA_W = IR_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output ir_ctrl_t          ctrl_o
);
  ir_ctrl_t ctrl_q;
  ir_ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en_i) begin
      ctrl_d.en_hi = wr_data_i[IR_BIT_ENHI];
      ctrl_d.en_lo = wr_data_i[IR_BIT_ENLO];
      ctrl_d.led   = wr_data_i[IR_BIT_LED];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/ir_light_detect.sv
module ir_light_detect #(
  parameter int unsigned NUM_SRC = ir_pkg::IR_NUM_SRC
) (
  input  logic [NUM_SRC-1:0] src_i,
  output logic               light_o
);
  logic [NUM_SRC:0] chain;

  assign chain[0] = 1'b0;
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign chain[g+1] = chain[g] | src_i[g];
  end

  assign light_o = chain[NUM_SRC];
endmodule

// File: rtl/ir_read_mux.sv
module ir_read_mux
  import ir_pkg::*;
#(
  parameter int unsigned DATA_W = IR_DATA_W
) (
  input  logic              color_mode_i,
  input  ir_ctrl_t          ctrl_i,
  input  logic              light_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] reg_view;

  always_comb begin
    reg_view                          = '0;
    reg_view[IR_BIT_ENHI]             = ctrl_i.en_hi;
    reg_view[IR_BIT_ENLO]             = ctrl_i.en_lo;
    reg_view[IR_FILL_HI:IR_FILL_LO]   = {IR_FILL_W{1'b1}};
    reg_view[IR_BIT_RX]               = ctrl_i.en_hi & ctrl_i.en_lo & light_i;
    reg_view[IR_BIT_LED]              = ctrl_i.led;
  end

  assign rd_data_o = color_mode_i ? reg_view : {DATA_W{1'b1}};
endmodule

// File: rtl/ir_status_reg.sv
module ir_status_reg
  import ir_pkg::*;
#(
  parameter int unsigned DATA_W = IR_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              color_mode_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              sensor_i,
  input  logic              cart_led_i
);
  ir_ctrl_t              ctrl_q;
  logic                  light;
  logic [IR_NUM_SRC-1:0] light_src;

  ir_ctrl_store #(.DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .ctrl_o    (ctrl_q)
  );

  assign light_src = {cart_led_i, ctrl_q.led, sensor_i};

  ir_light_detect #(.NUM_SRC(IR_NUM_SRC)) u_light (
    .src_i   (light_src),
    .light_o (light)
  );

  ir_read_mux #(.DATA_W(DATA_W)) u_rmux (
    .color_mode_i (color_mode_i),
    .ctrl_i       (ctrl_q),
    .light_i      (light),
    .rd_data_o    (rd_data_o)
  );
endmodule

// File: rtl/ir_status_reg_chk.sv
module ir_status_reg_chk
  import ir_pkg::*;
#(
  parameter int unsigned DATA_W = IR_DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              color_mode_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              sensor_i,
  input logic              cart_led_i,
  input ir_ctrl_t          ctrl_q
);
  assert_mono_ff_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !color_mode_i |-> rd_data_o == {DATA_W{1'b1}});

  assert_fill_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    color_mode_i |-> rd_data_o[IR_FILL_HI:IR_FILL_LO] == {IR_FILL_W{1'b1}});

  assert_stored_view_R3: assert property (@(posedge clk) disable iff (!rst_n)
    color_mode_i |-> (rd_data_o[IR_BIT_ENHI] == ctrl_q.en_hi &&
                      rd_data_o[IR_BIT_ENLO] == ctrl_q.en_lo &&
                      rd_data_o[IR_BIT_LED]  == ctrl_q.led));

  assert_rx_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (color_mode_i && rd_data_o[IR_BIT_RX]) |-> (ctrl_q.en_hi && ctrl_q.en_lo));

  assert_rx_seen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (color_mode_i && ctrl_q.en_hi && ctrl_q.en_lo &&
     (sensor_i || cart_led_i || ctrl_q.led)) |-> rd_data_o[IR_BIT_RX]);

  assert_write_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> ctrl_q == {$past(wr_data_i[IR_BIT_ENHI]),
                           $past(wr_data_i[IR_BIT_ENLO]),
                           $past(wr_data_i[IR_BIT_LED])});

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(ctrl_q));
endmodule

bind ir_status_reg ir_status_reg_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .color_mode_i (color_mode_i),
  .wr_en_i      (wr_en_i),
  .wr_data_i    (wr_data_i),
  .rd_data_o    (rd_data_o),
  .sensor_i     (sensor_i),
  .cart_led_i   (cart_led_i),
  .ctrl_q       (ctrl_q)
);

// File: tb/ir_status_reg_tb.sv
module ir_status_reg_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       color_mode_i = 1'b1;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic       sensor_i = 1'b0;
  logic       cart_led_i = 1'b0;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  logic [2:0]  m_ctrl   = '0;   // model: {en_hi, en_lo, led}

  always #2 clk = ~clk;          // 250 MHz

  ir_status_reg u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .color_mode_i (color_mode_i),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .rd_data_o    (rd_data_o),
    .sensor_i     (sensor_i),
    .cart_led_i   (cart_led_i)
  );

  function automatic logic [7:0] exp_read(logic cm, logic [2:0] c, logic s, logic k);
    logic lit;
    if (!cm) return 8'hFF;
    lit = s | c[0] | k;
    return {c[2], c[1], 4'hF, c[2] & c[1] & lit, c[0]};
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: rd_data_o=%02h expected %02h", tag, got, exp);
    end
  endtask

  // field-level check of the current read value against the model
  task automatic check_fields();
    logic [7:0] e;
    e = exp_read(color_mode_i, m_ctrl, sensor_i, cart_led_i);
    if (!color_mode_i) check("R1", rd_data_o, e);
    else begin
      check("R2", {4'h0, rd_data_o[5:2]}, {4'h0, e[5:2]});
      check("R3", {rd_data_o[7:6], 5'h0, rd_data_o[0]}, {e[7:6], 5'h0, e[0]});
      check("R4", {7'h0, rd_data_o[1]}, {7'h0, e[1]});
    end
  endtask

  task automatic do_write(logic [7:0] v);
    @(negedge clk);
    wr_en_i = 1'b1; wr_data_i = v;
    @(posedge clk); #1;
    wr_en_i = 1'b0;
    m_ctrl = {v[7], v[6], v[0]};
  endtask

  task automatic set_in(logic cm, logic s, logic k);
    color_mode_i = cm; sensor_i = s; cart_led_i = k; #1;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240613));
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    @(negedge clk);

    // R7: reset state
    set_in(1'b1, 1'b0, 1'b0);
    check("R7", rd_data_o, 8'h3C);
    set_in(1'b1, 1'b1, 1'b1);
    check("R7", rd_data_o, 8'h3C);   // enables off: no rx flag

    // R1: monochrome reads all ones
    set_in(1'b0, 1'b0, 1'b0);
    check("R1", rd_data_o, 8'hFF);

    // R5: own LED seen
    do_write(8'hC1);
    set_in(1'b1, 1'b0, 1'b0);
    check("R5", rd_data_o, 8'hFF);
    // R5: cartridge LED only
    do_write(8'hC0);
    set_in(1'b1, 1'b0, 1'b1);
    check("R5", rd_data_o, 8'hFE);
    // R5: sensor only
    set_in(1'b1, 1'b1, 1'b0);
    check("R5", rd_data_o, 8'hFE);
    // R5: no source
    set_in(1'b1, 1'b0, 1'b0);
    check("R5", rd_data_o, 8'hFC);
    // R4: only one enable bit set
    do_write(8'h81);
    set_in(1'b1, 1'b1, 1'b1);
    check("R4", rd_data_o, 8'hBD);
    // R6: written bits 5..1 ignored, bit 1 does not leak into rx flag
    do_write(8'h3E);
    set_in(1'b1, 1'b0, 1'b0);
    check("R6", rd_data_o, 8'h3C);
    // R1: monochrome hides stored state
    do_write(8'hC1);
    set_in(1'b0, 1'b1, 1'b1);
    check("R1", rd_data_o, 8'hFF);
    // R8: no strobe -> stored bits hold across an edge
    @(negedge clk);
    wr_data_i = 8'h00;
    @(posedge clk); #1;
    set_in(1'b1, 1'b0, 1'b0);
    check("R8", rd_data_o, 8'hFF);
    // R8: write value not visible before its edge
    @(negedge clk);
    wr_en_i = 1'b1; wr_data_i = 8'h00; #1;
    check("R8", rd_data_o, 8'hFF);
    @(posedge clk); #1;
    wr_en_i = 1'b0; m_ctrl = '0;
    check("R8", rd_data_o, 8'h3C);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic       w;
      logic [7:0] v;
      w = ($urandom % 3) != 0;
      v = 8'($urandom);
      @(negedge clk);
      wr_en_i   = w;
      wr_data_i = v;
      @(posedge clk); #1;
      wr_en_i = 1'b0;
      if (w) m_ctrl = {v[7], v[6], v[0]};
      set_in(1'($urandom % 5 != 0), 1'($urandom), 1'($urandom));
      check_fields();
      if (w && color_mode_i)
        check("R6", {rd_data_o[7:6], 5'h0, rd_data_o[0]}, {v[7:6], 5'h0, v[0]});
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule